// File: doc/BRIEF.md
# Video-Mode Frame and Line Timing Sequencer

This block paces a serial display link that runs in burst video mode. Software first programs four vertical line counts: sync, back porch, active and front porch. It also programs three horizontal durations counted in lane byte clock cycles: sync width, back-porch width and total line length. Software converts each horizontal duration from pixels into byte-clock cycles, rounding up, before it loads the value. The horizontal front porch has no register of its own. It is the part of the line that is left after the other horizontal regions.

While `en` is high, the sequencer walks through the frame one byte-clock cycle at a time. It marks the start and end of every sync pulse. It asks for one pixel packet on each active line. It raises a flag wherever a six-bit permission field allows the lanes to drop to low power. It pulses `frame_done` on the final cycle of each frame. Writes made while the sequencer runs go into staging registers, and the block takes them up only at a frame boundary.

A separate path normalizes the sync, data-enable, shutdown and colour-mode inputs of the parallel pixel interface. Each of these inputs is inverted or passed through according to a programmed polarity.

Top module: `vtseq_top`

## Requirements
- R1: After a synchronous active-low reset, all timing event outputs, `lp_allow`, `frame_done`, `cfg_err` and `pkt_pixels` are 0. The polarity selects are 0, so each `*_norm` output equals its pin.
- R2: A frame is made of the vertical regions in the fixed order sync, back porch, active, front porch, with the programmed number of lines in each. A region whose count is 0 is skipped. `vregion` reports the current region while running, encoded sync=0, back porch=1, active=2, front porch=3.
- R3: Every line lasts `hline` cycles, counted from cycle 0. On sync lines, `vs_start` is high in cycle 0 and `vs_end` is high in cycle `hsa`. On all other lines, `hs_start` and `hs_end` are high in those same cycles instead.
- R4: `pkt_req` is high for exactly one cycle on each active line, in cycle `hsa+hbp`, and on no other line.
- R5: `lp_allow` is 0 while the cycle index is below `hsa`. Past that point it follows the low-power field as follows:
  - Sync lines use bit 0, back-porch lines use bit 1 and front-porch lines use bit 3.
  - On active lines, cycles below `hsa+hbp` use bit 4.
  - The request cycle itself gives 0.
  - Later cycles of an active line need both bit 2 and bit 5.
- R6: `frame_done` is high for one cycle, on the last cycle of the last line of the frame. If `en` stays high, the next frame starts in the following cycle.
- R7: Register writes use `cfg_addr` with the following map: 0 sync lines, 1 back-porch lines, 2 active lines, 3 front-porch lines, 4 sync cycles, 5 back-porch cycles, 6 line cycles, 7 packet pixel count (14-bit field), 8 low-power field, 9 polarity. While idle, written timing values take effect at once. While running, they take effect only from the next frame on, and this includes `pkt_pixels`.
- R8: A write to any of the addresses 0 to 3 or 7 whose data exceeds 0x7FF is discarded, and the register keeps its old value. In the cycle after such a write, `cfg_err` is high for one cycle. A write of exactly 0x7FF is accepted.
- R9: Each `*_norm` output equals its pin XOR its polarity bit, with data enable at bit 0, vsync at bit 1, hsync at bit 2, shutdown at bit 3 and colour mode at bit 4. A polarity write takes effect in the next cycle.
- R10: If `en` is low at a clock edge, no event, `lp_allow` or `frame_done` output is high in the following cycle. When `en` rises again, the frame restarts from cycle 0 of its first line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the sequencer |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pin_de | input | 1 | Pixel interface data enable |
| pin_vs | input | 1 | Pixel interface vsync |
| pin_hs | input | 1 | Pixel interface hsync |
| pin_sd | input | 1 | Pixel interface shutdown |
| pin_cm | input | 1 | Pixel interface colour mode |
| vs_start | output | 1 | Vertical sync start event |
| vs_end | output | 1 | Vertical sync end event |
| hs_start | output | 1 | Horizontal sync start event |
| hs_end | output | 1 | Horizontal sync end event |
| pkt_req | output | 1 | Pixel packet request |
| pkt_pixels | output | 14 | Pixels per packet for the current frame |
| lp_allow | output | 1 | Low-power state permitted |
| vregion | output | 2 | Current vertical region |
| frame_done | output | 1 | Last cycle of the frame |
| cfg_err | output | 1 | Over-limit write was rejected |
| de_norm | output | 1 | Normalized data enable |
| vs_norm | output | 1 | Normalized vsync |
| hs_norm | output | 1 | Normalized hsync |
| sd_norm | output | 1 | Normalized shutdown |
| cm_norm | output | 1 | Normalized colour mode |

## Verification
The bench builds the block with its default parameters: 11-bit line counts, 16-bit cycle counts, a 14-bit pixel field and 32-bit write data. With these values, the 11-bit limit falls inside the write data, so rejecting 0x800 and accepting 0x7FF can both be exercised. Frames are kept to a few lines and a few cycles per line, so every cycle of several whole frames can be compared against a model computed from the requirements. That window covers:
- zero-count regions;
- a configuration update that is staged in the middle of a frame;
- a restart in the middle of a frame.

// File: rtl/vtseq_pkg.sv
// Shared constants of the video timing sequencer: register addresses,
// region codes and bit positions of the low-power and polarity fields.
package vtseq_pkg;
    localparam int ADDR_W   = 4;
    localparam int LP_BITS  = 6;
    localparam int POL_BITS = 5;
    localparam int N_VREG   = 4;

    // Vertical regions; the code equals the register address of the count
    localparam logic [1:0] RG_SYNC  = 2'd0;
    localparam logic [1:0] RG_BACK  = 2'd1;
    localparam logic [1:0] RG_ACT   = 2'd2;
    localparam logic [1:0] RG_FRONT = 2'd3;

    localparam logic [ADDR_W-1:0] A_HSA   = 4'd4;
    localparam logic [ADDR_W-1:0] A_HBP   = 4'd5;
    localparam logic [ADDR_W-1:0] A_HLINE = 4'd6;
    localparam logic [ADDR_W-1:0] A_PIX   = 4'd7;
    localparam logic [ADDR_W-1:0] A_LP    = 4'd8;
    localparam logic [ADDR_W-1:0] A_POL   = 4'd9;

    // Low-power permission bit positions
    localparam int LPB_VSYNC  = 0;
    localparam int LPB_VBACK  = 1;
    localparam int LPB_VACT   = 2;
    localparam int LPB_VFRONT = 3;
    localparam int LPB_HBACK  = 4;
    localparam int LPB_HFRONT = 5;

    // Polarity select bit positions
    localparam int POL_DE = 0;
    localparam int POL_VS = 1;
    localparam int POL_HS = 2;
    localparam int POL_SD = 3;
    localparam int POL_CM = 4;
endpackage

// File: rtl/vtseq_cfg.sv
// Staging registers of the sequencer.
// Checks each line count and the pixel count against the limit
// 2**LINE_W-1 and rejects writes above it, pulsing cfg_err.
// Assumes DATA_W > LINE_W and PIX_W >= LINE_W.
module vtseq_cfg
    import vtseq_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int HCYC_W = 16,
    parameter int PIX_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [N_VREG-1:0][LINE_W-1:0] st_vl,
    output logic [HCYC_W-1:0]            st_hsa,
    output logic [HCYC_W-1:0]            st_hbp,
    output logic [HCYC_W-1:0]            st_hline,
    output logic [PIX_W-1:0]             st_pix,
    output logic [LP_BITS-1:0]           st_lp,
    output logic [POL_BITS-1:0]          pol,
    output logic                         cfg_err
);
    logic over_lim;
    logic lim_tgt;

    assign over_lim = |wdata[DATA_W-1:LINE_W];
    assign lim_tgt  = (addr < ADDR_W'(N_VREG)) || (addr == A_PIX);

    // One staged line count per vertical region
    for (genvar k = 0; k < N_VREG; k++) begin : g_vl
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_vl[k] <= '0;
            else if (we && addr == ADDR_W'(k) && !over_lim)
                st_vl[k] <= wdata[LINE_W-1:0];
        end
    end

    // Horizontal durations, packet size, low-power field and polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_hsa   <= '0;
            st_hbp   <= '0;
            st_hline <= '0;
            st_pix   <= '0;
            st_lp    <= '0;
            pol      <= '0;
        end else if (we) begin
            case (addr)
                A_HSA:   st_hsa   <= wdata[HCYC_W-1:0];
                A_HBP:   st_hbp   <= wdata[HCYC_W-1:0];
                A_HLINE: st_hline <= wdata[HCYC_W-1:0];
                A_PIX:   if (!over_lim) st_pix <= wdata[PIX_W-1:0];
                A_LP:    st_lp    <= wdata[LP_BITS-1:0];
                A_POL:   pol      <= wdata[POL_BITS-1:0];
                default: ;
            endcase
        end
    end

    // Flag a rejected over-limit write for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= we && lim_tgt && over_lim;
    end
endmodule

// File: rtl/vtseq_hcnt.sv
// Horizontal cycle counter.
// Counts from 0 to hline-1 while running and marks the last cycle of the line.
// Assumes hline >= 2.
module vtseq_hcnt #(
    parameter int HCYC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HCYC_W-1:0] hline,
    output logic [HCYC_W-1:0] hcnt,
    output logic              line_end
);
    assign line_end = run && (hcnt == hline - 1'b1);

    // Advance within the line and wrap at its end
    always_ff @(posedge clk) begin
        if (!rst_n)                hcnt <= '0;
        else if (!run || line_end) hcnt <= '0;
        else                       hcnt <= hcnt + 1'b1;
    end
endmodule

// File: rtl/vtseq_vcnt.sv
// Vertical region and line tracker.
// Steps through the regions in code order and skips regions with a count of 0.
// It flags the end of the frame after the last line of the last non-empty region.
// While idle, and at the end of each frame, it reloads the first non-empty region
// from the staged counts.
// Assumes at least one count is non-zero.
module vtseq_vcnt
    import vtseq_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          line_end,
    input  logic [N_VREG-1:0][LINE_W-1:0] act_vl,
    input  logic [N_VREG-1:0][LINE_W-1:0] st_vl,
    output logic [1:0]                    region,
    output logic                          frame_end
);
    logic [LINE_W-1:0] line;
    logic              last_line;
    logic              nxt_found;
    logic [1:0]        nxt_rg;
    logic [1:0]        start_rg;

    assign last_line = (line == act_vl[region] - 1'b1);
    assign frame_end = line_end && last_line && !nxt_found;

    // Lowest non-empty region of the staged counts
    always_comb begin
        start_rg = RG_SYNC;
        for (int i = N_VREG - 1; i >= 0; i--)
            if (st_vl[i] != '0) start_rg = 2'(i);
    end

    // Next non-empty region after the current one
    always_comb begin
        nxt_found = 1'b0;
        nxt_rg    = region;
        for (int i = N_VREG - 1; i >= 1; i--) begin
            if (i > int'(region) && act_vl[i] != '0) begin
                nxt_found = 1'b1;
                nxt_rg    = 2'(i);
            end
        end
    end

    // Region and line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region <= RG_SYNC;
            line   <= '0;
        end else if (!run || frame_end) begin
            region <= start_rg;
            line   <= '0;
        end else if (line_end) begin
            if (last_line) begin
                region <= nxt_rg;
                line   <= '0;
            end else begin
                line <= line + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vtseq_evt.sv
// Event decoder. From the current region and cycle index it forms:
//   - the sync start and end events;
//   - the packet request;
//   - the low-power permission.
// Purely combinational. Assumes hsa >= 1.
module vtseq_evt
    import vtseq_pkg::*;
#(
    parameter int HCYC_W = 16
) (
    input  logic               run,
    input  logic [1:0]         region,
    input  logic [HCYC_W-1:0]  hcnt,
    input  logic [HCYC_W-1:0]  hsa,
    input  logic [HCYC_W-1:0]  hbp,
    input  logic [LP_BITS-1:0] lp,
    output logic               vs_start,
    output logic               vs_end,
    output logic               hs_start,
    output logic               hs_end,
    output logic               pkt_req,
    output logic               lp_allow
);
    logic [HCYC_W:0] hc_x;
    logic [HCYC_W:0] pkt_pt;
    logic            is_sync;
    logic            at_zero;
    logic            at_hsa;

    assign hc_x    = {1'b0, hcnt};
    assign pkt_pt  = {1'b0, hsa} + {1'b0, hbp};
    assign is_sync = (region == RG_SYNC);
    assign at_zero = (hcnt == '0);
    assign at_hsa  = (hcnt == hsa);

    // Sync edges and packet request
    always_comb begin
        vs_start = run &&  is_sync && at_zero;
        vs_end   = run &&  is_sync && at_hsa;
        hs_start = run && !is_sync && at_zero;
        hs_end   = run && !is_sync && at_hsa;
        pkt_req  = run && (region == RG_ACT) && (hc_x == pkt_pt);
    end

    // Low-power permission per region
    always_comb begin
        lp_allow = 1'b0;
        if (run && hcnt >= hsa) begin
            case (region)
                RG_SYNC:  lp_allow = lp[LPB_VSYNC];
                RG_BACK:  lp_allow = lp[LPB_VBACK];
                RG_FRONT: lp_allow = lp[LPB_VFRONT];
                default: begin
                    if (hc_x < pkt_pt)       lp_allow = lp[LPB_HBACK];
                    else if (hc_x == pkt_pt) lp_allow = 1'b0;
                    else                     lp_allow = lp[LPB_VACT] & lp[LPB_HFRONT];
                end
            endcase
        end
    end
endmodule

// File: rtl/vtseq_top.sv
// Video-mode frame and line timing sequencer.
// Holds the active copy of every timing value and refreshes it from staging
// while idle or at a frame boundary. Ties together the counters and the event
// decoder, and normalizes the pixel interface pins.
module vtseq_top
    import vtseq_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int HCYC_W = 16,
    parameter int PIX_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pin_de,
    input  logic              pin_vs,
    input  logic              pin_hs,
    input  logic              pin_sd,
    input  logic              pin_cm,
    output logic              vs_start,
    output logic              vs_end,
    output logic              hs_start,
    output logic              hs_end,
    output logic              pkt_req,
    output logic [PIX_W-1:0]  pkt_pixels,
    output logic              lp_allow,
    output logic [1:0]        vregion,
    output logic              frame_done,
    output logic              cfg_err,
    output logic              de_norm,
    output logic              vs_norm,
    output logic              hs_norm,
    output logic              sd_norm,
    output logic              cm_norm
);
    logic [N_VREG-1:0][LINE_W-1:0] st_vl, act_vl;
    logic [HCYC_W-1:0]  st_hsa, st_hbp, st_hline;
    logic [HCYC_W-1:0]  act_hsa, act_hbp, act_hline;
    logic [PIX_W-1:0]   st_pix;
    logic [LP_BITS-1:0] st_lp, act_lp;
    logic [POL_BITS-1:0] pol;
    logic               run;
    logic [HCYC_W-1:0]  hcnt;
    logic               line_end;
    logic               frame_end;
    logic [1:0]         region;

    vtseq_cfg #(
        .LINE_W(LINE_W), .HCYC_W(HCYC_W), .PIX_W(PIX_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .st_vl(st_vl), .st_hsa(st_hsa), .st_hbp(st_hbp), .st_hline(st_hline),
        .st_pix(st_pix), .st_lp(st_lp), .pol(pol), .cfg_err(cfg_err)
    );

    // Running flag follows the enable input
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= en;
    end

    // Active timing copy, refreshed while idle or at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_vl     <= '0;
            act_hsa    <= '0;
            act_hbp    <= '0;
            act_hline  <= '0;
            act_lp     <= '0;
            pkt_pixels <= '0;
        end else if (!run || frame_end) begin
            act_vl     <= st_vl;
            act_hsa    <= st_hsa;
            act_hbp    <= st_hbp;
            act_hline  <= st_hline;
            act_lp     <= st_lp;
            pkt_pixels <= st_pix;
        end
    end

    vtseq_hcnt #(.HCYC_W(HCYC_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .run(run), .hline(act_hline),
        .hcnt(hcnt), .line_end(line_end)
    );

    vtseq_vcnt #(.LINE_W(LINE_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
        .act_vl(act_vl), .st_vl(st_vl), .region(region), .frame_end(frame_end)
    );

    vtseq_evt #(.HCYC_W(HCYC_W)) u_evt (
        .run(run), .region(region), .hcnt(hcnt), .hsa(act_hsa), .hbp(act_hbp),
        .lp(act_lp), .vs_start(vs_start), .vs_end(vs_end), .hs_start(hs_start),
        .hs_end(hs_end), .pkt_req(pkt_req), .lp_allow(lp_allow)
    );

    assign vregion    = region;
    assign frame_done = frame_end;

    // Pixel interface pin normalization
    assign de_norm = pin_de ^ pol[POL_DE];
    assign vs_norm = pin_vs ^ pol[POL_VS];
    assign hs_norm = pin_hs ^ pol[POL_HS];
    assign sd_norm = pin_sd ^ pol[POL_SD];
    assign cm_norm = pin_cm ^ pol[POL_CM];
endmodule

// File: rtl/vtseq_chk.sv
// Property checker for vtseq_top, attached to it by the bind statement below.
// Assumes hsa >= 1 and hline >= 2, as the design does.
module vtseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       cfg_we,
    input logic       vs_start,
    input logic       vs_end,
    input logic       hs_start,
    input logic       hs_end,
    input logic       pkt_req,
    input logic       lp_allow,
    input logic [1:0] vregion,
    input logic       frame_done,
    input logic       cfg_err
);
    a_r3_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vs_start, vs_end, hs_start, hs_end}));

    a_r3_vsync_in_sync_region: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_start || vs_end) |-> vregion == 2'd0);

    a_r4_pkt_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> vregion == 2'd2);

    a_r5_no_lp_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_start || hs_start) |-> !lp_allow);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r6_next_frame_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && en) |=> (vs_start || hs_start));

    a_r8_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we));

    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(vs_start || vs_end || hs_start || hs_end || pkt_req || lp_allow || frame_done));
endmodule

bind vtseq_top vtseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
    .vs_start(vs_start), .vs_end(vs_end), .hs_start(hs_start), .hs_end(hs_end),
    .pkt_req(pkt_req), .lp_allow(lp_allow), .vregion(vregion),
    .frame_done(frame_done), .cfg_err(cfg_err)
);

// File: tb/vtseq_top_bench.sv
// Self-checking bench for vtseq_top.
// Each run of frames is compared cycle by cycle against a model computed from
// the requirements.
module vtseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pin_de = 0, pin_vs = 0, pin_hs = 0, pin_sd = 0, pin_cm = 0;
    logic        vs_start, vs_end, hs_start, hs_end, pkt_req, lp_allow;
    logic        frame_done, cfg_err;
    logic [13:0] pkt_pixels;
    logic [1:0]  vregion;
    logic        de_norm, vs_norm, hs_norm, sd_norm, cm_norm;

    int nchk = 0;
    int nfail = 0;

    typedef struct {
        int vl[4];
        int hsa, hbp, hline, lp, pix;
    } cfg_t;

    int wr_a[16];
    int wr_d[16];
    int nwr = 0;

    always #10 clk = ~clk;

    vtseq_top u_vtseq_top (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_de(pin_de), .pin_vs(pin_vs), .pin_hs(pin_hs),
        .pin_sd(pin_sd), .pin_cm(pin_cm), .vs_start(vs_start), .vs_end(vs_end),
        .hs_start(hs_start), .hs_end(hs_end), .pkt_req(pkt_req),
        .pkt_pixels(pkt_pixels), .lp_allow(lp_allow), .vregion(vregion),
        .frame_done(frame_done), .cfg_err(cfg_err), .de_norm(de_norm),
        .vs_norm(vs_norm), .hs_norm(hs_norm), .sd_norm(sd_norm), .cm_norm(cm_norm)
    );

    function automatic int flen(input cfg_t c);
        return (c.vl[0] + c.vl[1] + c.vl[2] + c.vl[3]) * c.hline;
    endfunction

    // Expected {vs_start,vs_end,hs_start,hs_end,pkt_req,lp_allow,frame_done,vregion}
    function automatic logic [8:0] model(input cfg_t c, input int t);
        int ln, h, rg, base, pp;
        logic found, vss, vse, hss, hse, pk, lp, fd;
        ln = t / c.hline;
        h = t % c.hline;
        rg = 3;
        base = 0;
        found = 0;
        for (int i = 0; i < 4; i++) begin
            if (!found && ln < base + c.vl[i]) begin
                rg = i;
                found = 1;
            end
            base += c.vl[i];
        end
        pp = c.hsa + c.hbp;
        vss = (rg == 0) && (h == 0);
        vse = (rg == 0) && (h == c.hsa);
        hss = (rg != 0) && (h == 0);
        hse = (rg != 0) && (h == c.hsa);
        pk = (rg == 2) && (h == pp);
        if (h < c.hsa) lp = 0;
        else if (rg == 0) lp = c.lp[0];
        else if (rg == 1) lp = c.lp[1];
        else if (rg == 3) lp = c.lp[3];
        else if (h < pp) lp = c.lp[4];
        else if (h == pp) lp = 0;
        else lp = c.lp[2] & c.lp[5];
        fd = (t == flen(c) - 1);
        return {vss, vse, hss, hse, pk, lp, fd, 2'(rg)};
    endfunction

    function automatic cfg_t rand_cfg();
        cfg_t c;
        c.vl[0] = 1 + int'($urandom % 3);
        c.vl[1] = int'($urandom % 3);
        c.vl[2] = 1 + int'($urandom % 4);
        c.vl[3] = int'($urandom % 3);
        c.hsa = 1 + int'($urandom % 3);
        c.hbp = 1 + int'($urandom % 4);
        c.hline = c.hsa + c.hbp + 2 + int'($urandom % 6);
        c.lp = int'($urandom % 64);
        c.pix = int'($urandom % 2048);
        return c;
    endfunction

    task automatic wr(input int a, input int d, output logic err);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = 32'(d);
        @(negedge clk);
        err = cfg_err;
        cfg_we = 1'b0;
    endtask

    task automatic program_cfg(input cfg_t c);
        logic e;
        for (int i = 0; i < 4; i++) wr(i, c.vl[i], e);
        wr(4, c.hsa, e);
        wr(5, c.hbp, e);
        wr(6, c.hline, e);
        wr(7, c.pix, e);
        wr(8, c.lp, e);
    endtask

    task automatic load_writes(input cfg_t c);
        for (int i = 0; i < 4; i++) begin
            wr_a[i] = i;
            wr_d[i] = c.vl[i];
        end
        wr_a[4] = 4; wr_d[4] = c.hsa;
        wr_a[5] = 5; wr_d[5] = c.hbp;
        wr_a[6] = 6; wr_d[6] = c.hline;
        wr_a[7] = 7; wr_d[7] = c.pix;
        wr_a[8] = 8; wr_d[8] = c.lp;
        nwr = 9;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Compare every cycle: R2 R3 R4 R5 R6 R7. Starts one cycle after en was raised.
    task automatic run_cmp(input cfg_t c0, input cfg_t c1, input int nfr, input int maxc);
        int g;
        g = 0;
        for (int f = 0; f < nfr; f++) begin
            cfg_t cc;
            if (f == 0) cc = c0;
            else cc = c1;
            for (int t = 0; t < flen(cc) && g < maxc; t++) begin
                logic [8:0] e;
                @(negedge clk);
                e = model(cc, t);
                nchk++;
                if ({vs_start, vs_end, hs_start, hs_end, pkt_req, lp_allow, frame_done, vregion} !== e
                    || pkt_pixels !== 14'(cc.pix)) begin
                    nfail++;
                    $display("FAIL R2/R3/R4/R5/R6/R7 frame %0d cycle %0d got %b/%h exp %b/%h",
                             f, t, {vs_start, vs_end, hs_start, hs_end, pkt_req, lp_allow,
                             frame_done, vregion}, pkt_pixels, e, 14'(cc.pix));
                end
                if (g < nwr) begin
                    cfg_we = 1'b1;
                    cfg_addr = 4'(wr_a[g]);
                    cfg_wdata = 32'(wr_d[g]);
                end else begin
                    cfg_we = 1'b0;
                end
                g++;
            end
        end
        cfg_we = 1'b0;
        nwr = 0;
    endtask

    task automatic check_quiet(input string tag);
        check(tag, {25'd0, vs_start, vs_end, hs_start, hs_end, pkt_req, lp_allow, frame_done}, 32'd0);
    endtask

    task automatic finish_run();
        en = 1'b0;
        @(negedge clk);
        check_quiet("R10 idle after en low");
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        cfg_t c, c2;
        logic e;
        void'($urandom(32'd20240917));

        // R1: reset state
        {pin_cm, pin_sd, pin_hs, pin_vs, pin_de} = 5'b10110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 events after reset");
        check("R1 cfg_err/pkt_pixels after reset", {17'd0, cfg_err, pkt_pixels}, 32'd0);
        check("R1 norm passthrough", {27'd0, cm_norm, sd_norm, hs_norm, vs_norm, de_norm}, 32'b10110);

        // R9: polarity normalization
        for (int k = 0; k < 6; k++) begin
            logic [4:0] p, pins;
            p = 5'($urandom);
            pins = 5'($urandom);
            wr(9, int'(p), e);
            {pin_cm, pin_sd, pin_hs, pin_vs, pin_de} = pins;
            @(negedge clk);
            check("R9 polarity", {27'd0, cm_norm, sd_norm, hs_norm, vs_norm, de_norm},
                  {27'd0, pins ^ p});
        end

        // R8: over-limit writes rejected and flagged
        c = rand_cfg();
        program_cfg(c);
        wr(2, 32'h800, e);
        check("R8 err on vact 0x800", {31'd0, e}, 32'd1);
        @(negedge clk);
        check("R8 err single cycle", {31'd0, cfg_err}, 32'd0);
        wr(7, 32'h900, e);
        check("R8 err on pix 0x900", {31'd0, e}, 32'd1);
        @(negedge clk);
        check("R8 pix unchanged", {18'd0, pkt_pixels}, 32'(c.pix));
        wr(7, 32'h7FF, e);
        check("R8 no err on 0x7FF", {31'd0, e}, 32'd0);
        @(negedge clk);
        check("R8 pix 0x7FF taken", {18'd0, pkt_pixels}, 32'h7FF);
        wr(7, c.pix, e);
        en = 1'b1;
        run_cmp(c, c, 1, 1 << 30);   // R8: vact kept its old count
        finish_run();

        // Random configurations, two frames each
        for (int r = 0; r < 6; r++) begin
            c = rand_cfg();
            program_cfg(c);
            en = 1'b1;
            run_cmp(c, c, 2, 1 << 30);
            finish_run();
        end

        // R2: empty sync and back-porch regions are skipped; R5 with all bits set
        c = rand_cfg();
        c.vl[0] = 0; c.vl[1] = 0; c.vl[3] = 2; c.lp = 63;
        program_cfg(c);
        en = 1'b1;
        run_cmp(c, c, 2, 1 << 30);
        finish_run();

        // R5: only the active-line tail bits set
        c = rand_cfg();
        c.lp = 6'b100100;
        program_cfg(c);
        en = 1'b1;
        run_cmp(c, c, 1, 1 << 30);
        finish_run();

        // R7: update staged during a frame applies from the next frame
        c = rand_cfg();
        c.hline += 4;
        c2 = rand_cfg();
        program_cfg(c);
        load_writes(c2);
        en = 1'b1;
        run_cmp(c, c2, 3, 1 << 30);
        finish_run();

        // R10: disable in the middle of a frame, then restart from the top
        c = rand_cfg();
        program_cfg(c);
        en = 1'b1;
        run_cmp(c, c, 1, 7);
        en = 1'b0;
        @(negedge clk);
        check_quiet("R10 quiet after mid-frame disable");
        en = 1'b1;
        run_cmp(c, c, 1, 1 << 30);
        finish_run();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule